// File: doc/BRIEF.md
# Double-to-Single Bit-Pattern Converter

This block turns a 64-bit IEEE-754 double-precision operand into a 32-bit single-precision bit pattern. It does this by selecting fields and shifting bits, and it does no arithmetic. Signalling NaNs stay signalling and their payload bits are copied, not quieted. Bits below the single-precision fraction are dropped with no rounding. Exponents that are too small for a single normal are shifted into the denormal range. Exponents that are too large are not saturated: the high exponent bits are simply selected. No flags are produced. The 32-bit pattern is driven on both halves of a 64-bit result word.

The block is a two-stage pipeline with valid/ready on both sides. An operand is taken at a clock edge where `in_valid` and `in_ready` are both high. A result is handed over at an edge where `out_valid` and `out_ready` are both high. The whole pipe advances or freezes as one unit. When a result is waiting and `out_ready` is low, `in_ready` falls and both stages hold. In every other cycle `in_ready` is high, so with `out_ready` held high the block takes one operand per cycle.

Top module: `dpsp_convert`

## Requirements
- R1: A synchronous active-high reset drives `out_valid` low from the next edge and clears the pipe. After reset, `in_ready` is high.
- R2: An operand taken at edge k appears on `out_data` with `out_valid` high right after edge k+1, as long as the pipe does not stall. With `out_ready` held high, one operand per cycle is accepted.
- R3: Packing of the result word uses these field positions. Bit 31 is the operand sign (bit 63). Bit 30 is exponent bit 10 (operand bit 62). Bits 29:23 are exponent bits 6:0 (operand bits 58:52). Bits 22:0 are fraction bits 51:29. Fraction bits 28:0 are dropped without rounding.
- R4: NaN operands are not quieted. A fraction with bit 51 clear keeps it clear, and payload bits 50:29 are copied unchanged.
- R5: An operand with exponent 0 and a non-zero fraction is a double denormal. Its working exponent is set to 1 and its implicit leading bit is cleared. The result is a zero carrying the operand's sign.
- R6: A working exponent below 897 with a non-zero extended fraction counts as tiny. The fraction, with its leading one at bit 52, is shifted right by 897 minus the exponent, and the exponent is forced to 896, which gives result exponent field 0. If the shift is greater than 63, the fraction becomes zero.
- R7: Zeros, infinities and large exponents take the same field-selection path with no special case. Exponent bits 9:7 are dropped: for example, biased exponent 1152 gives result exponent field 0x80.
- R8: Both halves of `out_data` (bits 63:32 and 31:0) carry the same 32-bit pattern.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Results leave in the order the operands entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand this cycle |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Single pattern replicated in both halves |

## Verification
The bench goes after the edges of the tiny range. It uses exponent 897, which must stay normal, and exponents 896, 874 and 873, where the shifted leading one lands on the last kept bit or falls just below it. A design with an off-by-one shift count would move or lose that bit. Signalling NaNs with payload only in bit 50 or bit 29 catch a design that quiets NaNs or takes its fraction window one bit off. All-ones low fraction bits expose any rounding. Signed denormals and the exponent 1152 case catch special-casing or a saturated exponent. A stall while two results are in flight checks that nothing is overwritten or reordered.

// File: rtl/dpsp_pkg.sv
package dpsp_pkg;
  parameter int DP_W      = 64;
  parameter int SP_W      = 32;
  parameter int EXP_W     = 11;
  parameter int FRAC_W    = 52;
  parameter int SP_FRAC_W = 23;
  // first biased double exponent that still maps to a single-precision normal
  parameter int TINY_EDGE = 897;
  localparam int TINY_EXP   = TINY_EDGE - 1;
  localparam int SHIFT_MAX  = DP_W - 1;
  localparam int XFRAC_W    = FRAC_W + 1;
  localparam int DROP_W     = FRAC_W - SP_FRAC_W;
  localparam int REPL       = DP_W / SP_W;

  typedef struct packed {
    logic               sign;
    logic [EXP_W-1:0]   exp;
    logic [XFRAC_W-1:0] frac;
  } dpsp_fields_t;
endpackage

// File: rtl/dpsp_decode.sv
module dpsp_decode
  import dpsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            v_i,
  input  logic [DP_W-1:0] d_i,
  output logic            v_o,
  output dpsp_fields_t    f_o
);
  dpsp_fields_t nxt;
  logic         denorm;

  always_comb begin
    nxt.sign = d_i[DP_W-1];
    nxt.exp  = d_i[DP_W-2 -: EXP_W];
    nxt.frac = {1'b1, d_i[FRAC_W-1:0]};
    denorm   = (nxt.exp == '0) && (d_i[FRAC_W-1:0] != '0);
    if (denorm) begin
      nxt.exp            = EXP_W'(1);
      nxt.frac[FRAC_W]   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      v_o <= 1'b0;
    else if (en)  v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) f_o <= nxt;
  end

  // R5: after decode an exponent of zero can only come from a true zero operand
  a_r5_denorm_override: assert property (@(posedge clk) disable iff (rst)
    (v_o && f_o.exp == '0) |-> (f_o.frac == {1'b1, {FRAC_W{1'b0}}}));
endmodule

// File: rtl/dpsp_pack.sv
module dpsp_pack
  import dpsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            v_i,
  input  dpsp_fields_t    f_i,
  output logic            v_o,
  output logic [DP_W-1:0] d_o
);
  logic               tiny;
  logic [EXP_W-1:0]   shamt;
  logic [EXP_W-1:0]   exp_w;
  logic [XFRAC_W-1:0] frac_w;
  logic [SP_W-1:0]    word;
  logic [DP_W-1:0]    wide;

  always_comb begin
    tiny   = (f_i.exp < EXP_W'(TINY_EDGE)) && (f_i.frac != '0);
    shamt  = EXP_W'(TINY_EDGE) - f_i.exp;
    exp_w  = f_i.exp;
    frac_w = f_i.frac;
    if (tiny) begin
      if (shamt > EXP_W'(SHIFT_MAX)) frac_w = '0;
      else                           frac_w = f_i.frac >> shamt;
      exp_w = EXP_W'(TINY_EXP);
    end
    word = {f_i.sign, exp_w[EXP_W-1], exp_w[6:0], frac_w[FRAC_W-1:DROP_W]};
  end

  for (genvar g = 0; g < REPL; g++) begin : g_rep
    assign wide[g*SP_W +: SP_W] = word;
  end

  always_ff @(posedge clk) begin
    if (rst)      v_o <= 1'b0;
    else if (en)  v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) d_o <= wide;
  end

  // R6: a tiny operand always leaves with a zero exponent field
  a_r6_tiny_exp_zero: assert property (@(posedge clk) disable iff (rst)
    (en && v_i && tiny) |=> (d_o[SP_W-2 -: 8] == 8'h00));
endmodule

// File: rtl/dpsp_convert.sv
module dpsp_convert
  import dpsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DP_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DP_W-1:0] out_data
);
  logic         adv;
  logic         s1_v;
  dpsp_fields_t s1_f;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  dpsp_decode u_dec (
    .clk (clk), .rst (rst), .en (adv),
    .v_i (in_valid), .d_i (in_data),
    .v_o (s1_v), .f_o (s1_f)
  );

  dpsp_pack u_pack (
    .clk (clk), .rst (rst), .en (adv),
    .v_i (s1_v), .f_i (s1_f),
    .v_o (out_valid), .d_o (out_data)
  );

  // R1: reset empties the output stage
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: a held result stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: input is refused only while a result waits
  a_r9_ready: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid);

  // R8: both halves agree whenever a result is presented
  a_r8_halves: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[DP_W-1:SP_W] == out_data[SP_W-1:0]));
endmodule

// File: tb/dpsp_convert_test.sv
module dpsp_convert_test;
  localparam int PER = 10;
  localparam int N   = 21;

  // operand, expected single pattern, requirement number
  localparam logic [63:0] VIN [N] = '{
    64'h3FF0000000000000, // R3 1.0
    64'hC000000000000000, // R3 -2.0
    64'h3FF000001FFFFFFF, // R3 dropped bits all ones, no rounding
    64'h3FFFFFFFFFFFFFFF, // R3
    64'h7FF0000000000000, // R7 +inf
    64'hFFF0000000000000, // R7 -inf
    64'h0000000000000000, // R7 +0
    64'h8000000000000000, // R7 -0
    64'h7FF4000000000000, // R4 signalling NaN
    64'h7FF8000000000000, // R4 quiet NaN
    64'hFFF0000020000000, // R4 payload at bit 29
    64'h0000000000000001, // R5 denormal
    64'h800FFFFFFFFFFFFF, // R5 negative denormal
    64'h3810000000000000, // R6 exp 897 stays normal
    64'h3800000000000000, // R6 exp 896 shift 1
    64'h36A0000000000000, // R6 exp 874 shift 23
    64'h3690000000000000, // R6 exp 873 shift 24
    64'hB410000000000000, // R6 shift 64
    64'h3807FFFFFFFFFFFF, // R6 shifted fraction
    64'h4800000000000000, // R7 exp 1152
    64'h47F0000000000000  // R7 exp 1151
  };
  localparam logic [31:0] VOUT [N] = '{
    32'h3F800000, 32'hC0000000, 32'h3F800000, 32'h3FFFFFFF,
    32'h7F800000, 32'hFF800000, 32'h00000000, 32'h80000000,
    32'h7FA00000, 32'h7FC00000, 32'hFF800001,
    32'h00000000, 32'h80000000,
    32'h00800000, 32'h00400000, 32'h00000001, 32'h00000000,
    32'h80000000, 32'h005FFFFF,
    32'h40000000, 32'h7F800000
  };
  localparam int VREQ [N] = '{3,3,3,3,7,7,7,7,4,4,4,5,5,6,6,6,6,6,6,7,7};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_mem [64];
  int          req_mem [64];
  int          wr_p = 0;
  int          rd_p = 0;
  bit          mon_on = 0;

  always #(PER/2) clk = ~clk;

  dpsp_convert uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  // drive one operand; returns once accepted
  task automatic send(input logic [63:0] d, input logic [31:0] e, input int r);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    exp_mem[wr_p % 64] = e;
    req_mem[wr_p % 64] = r;
    wr_p++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: results in order, replicated, held under stall
  logic        prev_stall = 0;
  logic [63:0] prev_data  = '0;
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R9 hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        chk(rd_p < wr_p, "R9 spurious result", out_data, 64'h0);
        if (rd_p < wr_p) begin
          checks++;
          if (out_data !== {exp_mem[rd_p % 64], exp_mem[rd_p % 64]}) begin
            fails++;
            $display("FAIL R%0d (and R8) item %0d: got %h expected %h",
                     req_mem[rd_p % 64], rd_p, out_data,
                     {exp_mem[rd_p % 64], exp_mem[rd_p % 64]});
          end
          rd_p++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else begin
      prev_stall = 0;
    end
  end

  initial begin
    #(PER * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'h1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
    mon_on = 1;

    // R2 latency: accept at edge k, valid right after edge k+1
    @(posedge clk); #1;
    send(VIN[0], VOUT[0], 2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 not early", 64'(out_valid), 64'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 valid after two edges", 64'(out_valid), 64'h1);
    @(posedge clk); #1;

    // vector table back to back; R2 throughput
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1;
      in_data  = VIN[i];
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 one per cycle", 64'(in_ready), 64'h1);
      exp_mem[wr_p % 64] = VOUT[i];
      req_mem[wr_p % 64] = VREQ[i];
      wr_p++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (4) @(posedge clk); #1;
    chk(rd_p == wr_p, "R2 all drained", 64'(rd_p), 64'(wr_p));

    // R9 back-pressure with two results in flight
    out_ready = 1'b0;
    send(VIN[8], VOUT[8], 9);
    send(VIN[14], VOUT[14], 9);
    fork
      send(VIN[19], VOUT[19], 9);
      begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R9 in_ready low when held", 64'(in_ready), 64'h0);
        chk(out_data == {VOUT[8], VOUT[8]}, "R9 head of line", out_data,
            {VOUT[8], VOUT[8]});
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    repeat (4) @(posedge clk); #1;
    chk(rd_p == wr_p, "R9 order and count", 64'(rd_p), 64'(wr_p));

    // R1 mid-stream reset drops in-flight data
    send(VIN[1], VOUT[1], 1);
    rst = 1'b1;
    mon_on = 0;
    wr_p = rd_p;
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset flushes", 64'(out_valid), 64'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 nothing after flush", 64'(out_valid), 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule